// File: doc/BRIEF.md
# Dual-Counter Peak Tracker with Readback Select

This block sits beside two 5-bit measurement counters, called P and N. Both counters run freely. The block presents each counter through its own 8-bit read-only view. A view shows either the counter's live value or a tracked extreme value.

A single compare register holds the tracked extreme, and the two counters share it. A 3-bit command word, held as a register value, controls it:

- Command 000 seeds the register for maximum tracking.
- Command 101 seeds it for minimum tracking.
- Command 001 makes the register follow counter P.
- Command 010 makes the register follow counter N.

Software typically seeds the register, then selects a counter, then reads that counter's view. That view now shows the largest or smallest value seen since seeding.

A sample strobe marks the cycles in which the counters hold values worth comparing. The command is evaluated on every rising clock edge. The compare register and the view selection therefore change one edge after a command or strobe. The live values in the views follow the counter inputs combinationally.

Top module: `peak_track_top`

## Requirements
- R1: After reset, both views show their live counter values, the compare value is 0 and maximum tracking is selected.
- R2: Each view is 8 bits wide. Bits 7:5 always read 0, and bits 4:0 carry the 5-bit value.
- R3: Command 000 clears the compare value to 0, selects maximum tracking, and makes both views show live values from the next edge.
- R4: Under command 001, the P view shows the compare value. On each edge with the strobe high, the compare value takes counter P if P is strictly greater (maximum mode). Meanwhile the N view shows live N.
- R5: Under command 010, the N view shows the compare value and is updated from counter N by the same rule. Meanwhile the P view shows live P.
- R6: Command 101 sets the compare value to 31, selects minimum tracking, and shows live values in both views. In minimum mode, a sampled counter replaces the compare value only when it is strictly smaller.
- R7: Commands 011, 100, 110 and 111 leave the compare value, the tracking mode and the view selection unchanged, and the strobe has no effect under them.
- R8: In a capture command with the strobe low, the compare value does not change.
- R9: A seeding command (000 or 101) issued together with a high strobe seeds the register; the sample is discarded.
- R10: Changing the capture from one counter to the other without seeding keeps the current compare value and continues tracking from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_p | input | 5 | Live value of counter P |
| cnt_n | input | 5 | Live value of counter N |
| sample | input | 1 | Strobe marking cycles in which counters are compared |
| cmd | input | 3 | Command register value |
| rd_p | output | 8 | View of counter P: live value or compare value |
| rd_n | output | 8 | View of counter N: live value or compare value |

## Verification
Two functions can collide in one cycle:

- **Seeding against sampling.** A seeding command arrives while the strobe is high with an extreme counter value (31 after a minimum run, 0 against a fresh minimum seed). The next capture is then issued with the strobe low, so the view exposes the seeded value unchanged. The check passes only if that value is the seed and not the discarded sample.
- **Counter switch against sampling.** A switch between counters happens on a strobed edge. The carried compare value must then be checked against the new counter's value in that same edge.

// File: rtl/peak_track_pkg.sv
package peak_track_pkg;

  typedef enum logic [1:0] {
    VIEW_LIVE = 2'd0,
    VIEW_P    = 2'd1,
    VIEW_N    = 2'd2
  } view_e;

  typedef enum logic {
    TRK_MAX = 1'b0,
    TRK_MIN = 1'b1
  } trk_e;

  localparam logic [2:0] CMD_SEED_MAX = 3'b000;
  localparam logic [2:0] CMD_CAP_P    = 3'b001;
  localparam logic [2:0] CMD_CAP_N    = 3'b010;
  localparam logic [2:0] CMD_SEED_MIN = 3'b101;

endpackage

// File: rtl/peak_cmd_decode.sv
module peak_cmd_decode (
  input  logic [2:0] cmd,
  input  logic       sample,
  output logic       seed_max,
  output logic       seed_min,
  output logic       cap_p,
  output logic       cap_n,
  output logic       upd
);
  import peak_track_pkg::*;

  always_comb begin
    seed_max = 1'b0;
    seed_min = 1'b0;
    cap_p    = 1'b0;
    cap_n    = 1'b0;
    unique case (cmd)
      CMD_SEED_MAX: seed_max = 1'b1;
      CMD_SEED_MIN: seed_min = 1'b1;
      CMD_CAP_P:    cap_p    = 1'b1;
      CMD_CAP_N:    cap_n    = 1'b1;
      default: ;
    endcase
  end

  // only capture commands let a strobe through
  assign upd = sample & (cap_p | cap_n);

endmodule

// File: rtl/peak_tracker.sv
module peak_tracker #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_max,
  input  logic             seed_min,
  input  logic             upd,
  input  logic [CNT_W-1:0] sel_val,
  output logic [CNT_W-1:0] peak_q,
  output logic             min_mode
);
  import peak_track_pkg::*;

  localparam logic [CNT_W-1:0] SEED_LO = '0;
  localparam logic [CNT_W-1:0] SEED_HI = '1;

  trk_e mode_q;
  logic better;

  assign better   = (mode_q == TRK_MIN) ? (sel_val < peak_q) : (sel_val > peak_q);
  assign min_mode = (mode_q == TRK_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak_q <= SEED_LO;
      mode_q <= TRK_MAX;
    end else if (seed_max) begin
      peak_q <= SEED_LO;
      mode_q <= TRK_MAX;
    end else if (seed_min) begin
      peak_q <= SEED_HI;
      mode_q <= TRK_MIN;
    end else if (upd && better) begin
      peak_q <= sel_val;
    end
  end

  AST_SEED_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    seed_max |=> (peak_q == SEED_LO) && !min_mode); // R3

  AST_SEED_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    seed_min |=> (peak_q == SEED_HI) && min_mode); // R6

  AST_MAX_NONDEC: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !min_mode && !seed_max && !seed_min) |=> peak_q >= $past(peak_q)); // R4

  AST_MIN_NONINC: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && min_mode && !seed_max && !seed_min) |=> peak_q <= $past(peak_q)); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !seed_max && !seed_min) |=> $stable(peak_q) && $stable(min_mode)); // R8

endmodule

// File: rtl/peak_readback.sv
module peak_readback #(
  parameter int CNT_W = 5,
  parameter int RD_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_max,
  input  logic             seed_min,
  input  logic             cap_p,
  input  logic             cap_n,
  input  logic [CNT_W-1:0] cnt_p,
  input  logic [CNT_W-1:0] cnt_n,
  input  logic [CNT_W-1:0] peak,
  output logic [RD_W-1:0]  rd_p,
  output logic [RD_W-1:0]  rd_n
);
  import peak_track_pkg::*;

  localparam int PAD_W = RD_W - CNT_W;

  view_e view_q;
  logic [1:0][CNT_W-1:0] live;
  logic [1:0][RD_W-1:0]  rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  view_q <= VIEW_LIVE;
    else if (seed_max || seed_min) view_q <= VIEW_LIVE;
    else if (cap_p)              view_q <= VIEW_P;
    else if (cap_n)              view_q <= VIEW_N;
  end

  assign live[0] = cnt_p;
  assign live[1] = cnt_n;

  for (genvar ch = 0; ch < 2; ch++) begin : g_view
    localparam view_e CH_VIEW = (ch == 0) ? VIEW_P : VIEW_N;
    assign rd[ch] = (view_q == CH_VIEW) ? {{PAD_W{1'b0}}, peak}
                                        : {{PAD_W{1'b0}}, live[ch]};
  end

  assign rd_p = rd[0];
  assign rd_n = rd[1];

  AST_VIEW_P: assert property (@(posedge clk) disable iff (!rst_n)
    cap_p |=> view_q == VIEW_P); // R4

  AST_VIEW_N: assert property (@(posedge clk) disable iff (!rst_n)
    cap_n |=> view_q == VIEW_N); // R5

  AST_VIEW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(seed_max || seed_min || cap_p || cap_n) |=> $stable(view_q)); // R7

endmodule

// File: rtl/peak_track_top.sv
module peak_track_top #(
  parameter int CNT_W = 5,
  parameter int RD_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_p,
  input  logic [CNT_W-1:0] cnt_n,
  input  logic             sample,
  input  logic [2:0]       cmd,
  output logic [RD_W-1:0]  rd_p,
  output logic [RD_W-1:0]  rd_n
);

  logic seed_max, seed_min, cap_p, cap_n, upd, min_mode;
  logic [CNT_W-1:0] sel_val, peak;

  peak_cmd_decode u_dec (
    .cmd(cmd), .sample(sample),
    .seed_max(seed_max), .seed_min(seed_min),
    .cap_p(cap_p), .cap_n(cap_n), .upd(upd)
  );

  assign sel_val = cap_n ? cnt_n : cnt_p;

  peak_tracker #(.CNT_W(CNT_W)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .seed_max(seed_max), .seed_min(seed_min), .upd(upd),
    .sel_val(sel_val), .peak_q(peak), .min_mode(min_mode)
  );

  peak_readback #(.CNT_W(CNT_W), .RD_W(RD_W)) u_rb (
    .clk(clk), .rst_n(rst_n),
    .seed_max(seed_max), .seed_min(seed_min),
    .cap_p(cap_p), .cap_n(cap_n),
    .cnt_p(cnt_p), .cnt_n(cnt_n), .peak(peak),
    .rd_p(rd_p), .rd_n(rd_n)
  );

  AST_UPPER_P: assert property (@(posedge clk) disable iff (!rst_n)
    rd_p[RD_W-1:CNT_W] == '0); // R2

  AST_UPPER_N: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n[RD_W-1:CNT_W] == '0); // R2

  AST_SEED_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_min && sample) |=> (peak == '1) && min_mode); // R9

endmodule

// File: tb/peak_track_top_tb_top.sv
module peak_track_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] cnt_p = '0, cnt_n = '0;
  logic       sample = 1'b0;
  logic [2:0] cmd = 3'b011;
  logic [7:0] rd_p, rd_n;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] ep;
    logic [7:0] en;
    string      tag;
  } exp_t;

  exp_t sb[$];

  // reference state built from the requirements
  logic [4:0] m_pk = '0;
  bit         m_min = 0;
  int         m_view = 0; // 0 live, 1 P, 2 N

  always #10 clk = ~clk;

  peak_track_top dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_p(cnt_p), .cnt_n(cnt_n),
    .sample(sample), .cmd(cmd), .rd_p(rd_p), .rd_n(rd_n)
  );

  task automatic step(input logic [2:0] c, input logic s,
                      input logic [4:0] p, input logic [4:0] n, input string tag);
    exp_t e;
    @(negedge clk);
    cmd = c; sample = s; cnt_p = p; cnt_n = n;
    case (c)
      3'b000: begin m_pk = 5'd0;  m_min = 0; m_view = 0; end
      3'b101: begin m_pk = 5'd31; m_min = 1; m_view = 0; end
      3'b001: begin
        m_view = 1;
        if (s && (m_min ? (p < m_pk) : (p > m_pk))) m_pk = p;
      end
      3'b010: begin
        m_view = 2;
        if (s && (m_min ? (n < m_pk) : (n > m_pk))) m_pk = n;
      end
      default: ;
    endcase
    e.ep  = {3'b000, (m_view == 1) ? m_pk : p};
    e.en  = {3'b000, (m_view == 2) ? m_pk : n};
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: results are stable 5 ns after the edge that follows a push
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (rd_p !== e.ep || rd_n !== e.en) begin
          bad++;
          $display("FAIL %s: rd_p=%0d rd_n=%0d expected rd_p=%0d rd_n=%0d",
                   e.tag, rd_p, rd_n, e.ep, e.en);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cnt_p = 5'd7; cnt_n = 5'd9;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(3'b011, 0, 7, 9, "R1 reset shows live");
    step(3'b000, 1, 3, 4, "R3 seed max live views");
    step(3'b001, 1, 5, 2, "R4 capture P first max");
    step(3'b001, 1, 3, 6, "R4 smaller P ignored, N live");
    step(3'b001, 1, 12, 1, "R4 larger P taken");
    step(3'b001, 0, 30, 0, "R8 no strobe no update");
    step(3'b001, 1, 12, 0, "R4 equal value kept");
    step(3'b010, 1, 1, 8, "R10 switch to N carries compare");
    step(3'b010, 1, 20, 17, "R10 N exceeds carried value");
    step(3'b100, 1, 31, 31, "R7 reserved 100 holds");
    step(3'b110, 1, 31, 0, "R7 reserved 110 holds");
    step(3'b111, 1, 30, 31, "R7 reserved 111 holds");
    step(3'b011, 1, 31, 31, "R7 reserved 011 holds");
    step(3'b010, 0, 4, 4, "R7 value unchanged after reserved");
    step(3'b101, 0, 9, 9, "R6 seed min live views");
    step(3'b001, 1, 14, 3, "R6 min capture P");
    step(3'b001, 1, 20, 3, "R6 larger ignored in min");
    step(3'b001, 1, 4, 0, "R6 smaller taken");
    step(3'b010, 1, 0, 0, "R6 N reaches zero");
    step(3'b000, 1, 31, 31, "R9 seed max with strobe");
    step(3'b001, 0, 2, 2, "R9 seed value not sample");
    step(3'b101, 1, 0, 0, "R9 seed min with strobe");
    step(3'b001, 0, 5, 5, "R9 min seed is 31");
    step(3'b000, 0, 0, 0, "R3 reseed max");
    step(3'b010, 1, 9, 22, "R5 capture N max");
    step(3'b010, 1, 31, 31, "R2 full value upper bits zero");
    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule